// File: doc/BRIEF.md
# Saturating Network Error Tally Counters

This block keeps three 8-bit statistics tallies for a network receive path: frames that arrived with a bad CRC, frames that ended on a misaligned bit boundary, and frames that were dropped because the receive buffer was full or the receiver was offline. Each source delivers a one-cycle pulse per frame. CRC and alignment pulses are counted only when the same cycle carries an address-accepted qualifier. Frames turned away by the address filter are therefore never tallied. Dropped-frame pulses are counted whatever that qualifier says.

A tally stops at 0xC0 and holds there. It raises a pending flag once its top bit is set, which is at a count of 0x80 or more. A maskable interrupt line merges the three flags, so a service routine can drain a tally long before it saturates. The host drains a tally with a read strobe and a select code. The read returns the value in the next cycle and clears the tally in the same clock edge. An event that lands on that edge becomes the first count of the new period.

Top module: `net_err_tally`

## Requirements
- R1: While `rst_n` is low at a rising edge, all three tallies clear to 0, `rd_data` clears to 0, and `irq` and `irq_pend` are 0 after that edge.
- R2: A cycle with `crc_err_evt` and `frame_addr_ok` both high adds one to the CRC tally (select code 0).
- R3: A cycle with `align_err_evt` and `frame_addr_ok` both high adds one to the alignment tally (select code 1).
- R4: `crc_err_evt` and `align_err_evt` have no effect in a cycle where `frame_addr_ok` is low.
- R5: A cycle with `miss_evt` high adds one to the dropped-frame tally (select code 2), regardless of `frame_addr_ok`.
- R6: A tally that has reached 0xC0 ignores further events and holds 0xC0 until it is read.
- R7: `irq_pend[i]` (bit 0 CRC, bit 1 alignment, bit 2 dropped) is 1 exactly while tally i is 0x80 or more.
- R8: `irq` is 1 exactly when some bit i has both `irq_pend[i]` and `irq_mask[i]` set.
- R9: A cycle with `rd_en` high and `rd_sel` in 0..2 loads that tally's value into `rd_data` at the next edge and clears the tally at that same edge. `rd_data` keeps its value in cycles without a read.
- R10: If the selected tally's qualified event arrives in the same cycle as its read, the tally becomes 1 after the edge, not 0.
- R11: A read with `rd_sel` equal to 3 loads 0 into `rd_data` and leaves every tally unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| crc_err_evt | input | 1 | One-cycle pulse: frame ended with a bad CRC |
| align_err_evt | input | 1 | One-cycle pulse: frame ended with an alignment error |
| miss_evt | input | 1 | One-cycle pulse: frame dropped (buffer full or receiver offline) |
| frame_addr_ok | input | 1 | Frame passed the address filter; qualifies the CRC and alignment pulses |
| rd_en | input | 1 | Read-and-clear strobe |
| rd_sel | input | 2 | Tally select: 0 CRC, 1 alignment, 2 dropped, 3 none |
| rd_data | output | 8 | Registered value of the last read |
| irq_mask | input | 3 | Per-tally interrupt enable, same bit order as `irq_pend` |
| irq_pend | output | 3 | Per-tally flag: tally is 0x80 or more |
| irq | output | 1 | OR of the enabled pending flags |

## Verification
Every tally update and every `rd_data` load happens at the first rising edge after the stimulus cycle. `irq_pend` and `irq` follow the tally registers combinationally, so they settle in that same cycle. The bench drives inputs on the falling edge. It steps a behavioural model at the rising edge and compares all outputs on the following falling edge, exactly one edge after each stimulus. Tallies are observed only through reads, so every read result is compared against the model's value from the cycle before the clear.

// File: rtl/net_tally_pkg.sv
// Package: shared sizing and tally index assignments for the error tally block.
// Assumes: three tallies, index order fixed as below (the read select decodes it).
package net_tally_pkg;
    localparam int TALLY_W   = 8;
    localparam int TALLY_N   = 3;
    localparam int TALLY_CEIL = 192;
    localparam int SEL_W     = $clog2(TALLY_N + 1);

    typedef enum logic [SEL_W-1:0] {
        SRC_CRC   = 2'd0,
        SRC_ALIGN = 2'd1,
        SRC_MISS  = 2'd2,
        SRC_NONE  = 2'd3
    } tally_src_e;
endpackage

// File: rtl/tally_evt_qual.sv
// Module: qualifies raw error pulses before they reach the tallies.
// CRC and alignment pulses need the address-accepted flag; dropped-frame pulses do not.
// Assumes: pulses are already synchronous to clk and last one cycle per frame.
module tally_evt_qual
    import net_tally_pkg::*;
(
    input  logic               crc_evt_i,
    input  logic               align_evt_i,
    input  logic               miss_evt_i,
    input  logic               addr_ok_i,
    output logic [TALLY_N-1:0] evt_o
);
    // Gate the address-dependent events and pass the dropped-frame event.
    always_comb begin
        evt_o           = '0;
        evt_o[SRC_CRC]   = crc_evt_i   & addr_ok_i;
        evt_o[SRC_ALIGN] = align_evt_i & addr_ok_i;
        evt_o[SRC_MISS]  = miss_evt_i;
    end
endmodule

// File: rtl/tally_counter.sv
// Module: one saturating tally with a read-clear input and a top-bit flag.
// Assumes: clr_i and evt_i may coincide; the event then starts the new period at 1.
module tally_counter #(
    parameter int W    = 8,
    parameter int CEIL = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o,
    output logic         msb_o
);
    localparam logic [W-1:0] CEIL_V = W'(CEIL);
    localparam logic [W-1:0] ONE_V  = W'(1);

    logic [W-1:0] cnt_q;
    logic         at_ceil;

    assign at_ceil = (cnt_q >= CEIL_V);

    // Advance, hold at the ceiling, or restart on a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= evt_i ? ONE_V : '0;
        else if (evt_i && !at_ceil)
            cnt_q <= cnt_q + ONE_V;
    end

    assign cnt_o = cnt_q;
    assign msb_o = cnt_q[W-1];

    // R6: never beyond the ceiling
    p_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CEIL_V);

    // R6: a saturated tally holds without a clear
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CEIL_V && !clr_i) |=> cnt_q == CEIL_V);

    // R2: one step per accepted event below the ceiling
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !clr_i && cnt_q < CEIL_V) |=> cnt_q == $past(cnt_q) + ONE_V);

    // R9: a clear without an event leaves zero
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> cnt_q == '0);

    // R10: a clear with an event leaves one
    p_clear_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && evt_i) |=> cnt_q == ONE_V);
endmodule

// File: rtl/tally_rd_port.sv
// Module: host read-and-clear port; decodes the select, registers the read value.
// Assumes: select codes at or above N are no-ops that return zero.
module tally_rd_port #(
    parameter int W     = 8,
    parameter int N     = 3,
    parameter int SEL_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en_i,
    input  logic [SEL_W-1:0]    rd_sel_i,
    input  logic [N-1:0][W-1:0] cnt_i,
    output logic [N-1:0]        clr_o,
    output logic [W-1:0]        rd_data_o
);
    logic [W-1:0] sel_val;
    logic [W-1:0] rd_q;

    // One clear strobe per tally, raised only for the selected index.
    for (genvar g = 0; g < N; g++) begin : g_clr
        assign clr_o[g] = rd_en_i && (rd_sel_i == SEL_W'(g));
    end

    // Pick the selected tally value, zero for an out-of-range code.
    always_comb begin
        sel_val = '0;
        for (int i = 0; i < N; i++)
            if (rd_sel_i == SEL_W'(i))
                sel_val = cnt_i[i];
    end

    // Capture the value on a read strobe; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_en_i)
            rd_q <= sel_val;
    end

    assign rd_data_o = rd_q;

    // R11: an out-of-range read returns zero
    p_bad_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && rd_sel_i >= SEL_W'(N)) |=> rd_q == '0);

    // R9: no read, no change of the read register
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_q));

    // R11: out-of-range codes raise no clear
    p_no_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel_i >= SEL_W'(N)) |-> clr_o == '0);
endmodule

// File: rtl/tally_irq_merge.sv
// Module: combines per-tally top-bit flags with the enable mask into one line.
// Assumes: the mask is static or changes only between service routines.
module tally_irq_merge #(
    parameter int N = 3
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);
    // Raise the line when any enabled flag is pending.
    always_comb begin
        irq_o = 1'b0;
        for (int i = 0; i < N; i++)
            irq_o = irq_o | (pend_i[i] & mask_i[i]);
    end
endmodule

// File: rtl/net_err_tally.sv
// Module: top of the error tally block; three saturating tallies, read-clear port,
// maskable interrupt. Assumes: event pulses and host strobes share clk.
module net_err_tally
    import net_tally_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               crc_err_evt,
    input  logic               align_err_evt,
    input  logic               miss_evt,
    input  logic               frame_addr_ok,
    input  logic               rd_en,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [TALLY_W-1:0] rd_data,
    input  logic [TALLY_N-1:0] irq_mask,
    output logic [TALLY_N-1:0] irq_pend,
    output logic               irq
);
    logic [TALLY_N-1:0]              evt_w;
    logic [TALLY_N-1:0]              clr_w;
    logic [TALLY_N-1:0][TALLY_W-1:0] cnt_w;

    tally_evt_qual i_qual (
        .crc_evt_i   (crc_err_evt),
        .align_evt_i (align_err_evt),
        .miss_evt_i  (miss_evt),
        .addr_ok_i   (frame_addr_ok),
        .evt_o       (evt_w)
    );

    for (genvar g = 0; g < TALLY_N; g++) begin : g_tally
        tally_counter #(.W(TALLY_W), .CEIL(TALLY_CEIL)) i_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_w[g]),
            .clr_i (clr_w[g]),
            .cnt_o (cnt_w[g]),
            .msb_o (irq_pend[g])
        );
    end

    tally_rd_port #(.W(TALLY_W), .N(TALLY_N), .SEL_W(SEL_W)) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en_i   (rd_en),
        .rd_sel_i  (rd_sel),
        .cnt_i     (cnt_w),
        .clr_o     (clr_w),
        .rd_data_o (rd_data)
    );

    tally_irq_merge #(.N(TALLY_N)) i_irq (
        .pend_i (irq_pend),
        .mask_i (irq_mask),
        .irq_o  (irq)
    );

    // R4: unqualified CRC pulses leave the CRC tally alone
    p_crc_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_addr_ok && !(rd_en && rd_sel == SRC_CRC)) |=> $stable(cnt_w[SRC_CRC]));

    // R4: unqualified alignment pulses leave the alignment tally alone
    p_align_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_addr_ok && !(rd_en && rd_sel == SRC_ALIGN)) |=> $stable(cnt_w[SRC_ALIGN]));

    // R5: a dropped-frame pulse below the ceiling always counts
    p_miss_counts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_evt && !(rd_en && rd_sel == SRC_MISS) && cnt_w[SRC_MISS] < TALLY_W'(TALLY_CEIL))
        |=> cnt_w[SRC_MISS] == $past(cnt_w[SRC_MISS]) + TALLY_W'(1));

    // R8: no enabled pending flag, no interrupt
    p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend & irq_mask) == '0) |-> !irq);

    // R1: state is cleared the cycle after reset
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && irq_pend == '0));
endmodule

// File: tb/test_net_err_tally.sv
`timescale 1ns/1ps
module test_net_err_tally;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       crc_err_evt, align_err_evt, miss_evt, frame_addr_ok;
    logic       rd_en;
    logic [1:0] rd_sel;
    logic [7:0] rd_data;
    logic [2:0] irq_mask;
    logic [2:0] irq_pend;
    logic       irq;

    int mcnt [3];
    int mrd;
    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    net_err_tally i_net_err_tally (
        .clk(clk), .rst_n(rst_n),
        .crc_err_evt(crc_err_evt), .align_err_evt(align_err_evt),
        .miss_evt(miss_evt), .frame_addr_ok(frame_addr_ok),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .irq_mask(irq_mask), .irq_pend(irq_pend), .irq(irq)
    );

    // Behavioural reference step at a rising edge.
    task automatic model_edge();
        bit q [3];
        q[0] = crc_err_evt && frame_addr_ok;
        q[1] = align_err_evt && frame_addr_ok;
        q[2] = miss_evt;
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) mcnt[i] = 0;
            mrd = 0;
        end else begin
            if (rd_en && rd_sel == 2'd3) mrd = 0;
            for (int i = 0; i < 3; i++) begin
                if (rd_en && rd_sel == i) begin
                    mrd = mcnt[i];
                    mcnt[i] = q[i] ? 1 : 0;
                end else if (q[i] && mcnt[i] < 192) begin
                    mcnt[i]++;
                end
            end
        end
    endtask

    task automatic compare(input string tag);
        int epend;
        int eirq;
        epend = 0;
        for (int i = 0; i < 3; i++) if (mcnt[i] >= 128) epend |= (1 << i);
        eirq = ((epend & irq_mask) != 0) ? 1 : 0;
        n_cmp++;
        if (rd_data !== 8'(mrd)) begin
            n_bad++;
            $display("FAIL %s rd_data actual=%0h expected=%0h", tag, rd_data, mrd);
        end
        n_cmp++;
        if (irq_pend !== 3'(epend)) begin
            n_bad++;
            $display("FAIL %s irq_pend actual=%0b expected=%0b", tag, irq_pend, epend);
        end
        n_cmp++;
        if (irq !== 1'(eirq)) begin
            n_bad++;
            $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, eirq);
        end
    endtask

    task automatic step(input bit c, input bit a, input bit m, input bit ok,
                        input bit rd, input logic [1:0] sel, input string tag);
        crc_err_evt = c; align_err_evt = a; miss_evt = m; frame_addr_ok = ok;
        rd_en = rd; rd_sel = sel;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 0, 0, 2'd0, tag);
    endtask

    task automatic read(input logic [1:0] sel, input string tag);
        step(0, 0, 0, 0, 1, sel, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; irq_mask = 3'b111;
        crc_err_evt = 0; align_err_evt = 0; miss_evt = 0; frame_addr_ok = 0;
        rd_en = 0; rd_sel = 0;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 1, 1, 1, 0, 2'd0, "R1");
        rst_n = 1'b1;
        idle("R1");
        // R2: CRC tally counts qualified pulses
        for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0, 2'd0, "R2");
        read(2'd0, "R2");
        read(2'd0, "R9");
        // R3: alignment tally
        for (int i = 0; i < 7; i++) step(0, 1, 0, 1, 0, 2'd0, "R3");
        read(2'd1, "R3");
        // R4: unqualified CRC and alignment pulses ignored
        for (int i = 0; i < 6; i++) step(1, 1, 0, 0, 0, 2'd0, "R4");
        read(2'd0, "R4");
        read(2'd1, "R4");
        // R5: dropped-frame tally ignores the qualifier
        for (int i = 0; i < 4; i++) step(0, 0, 1, i[0], 0, 2'd0, "R5");
        read(2'd2, "R5");
        // R11: out-of-range select, then confirm tallies were untouched
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, 2'd0, "R11");
        read(2'd3, "R11");
        read(2'd0, "R11");
        read(2'd2, "R11");
        // R7, R6: drive CRC tally through 0x80 to the ceiling and beyond
        for (int i = 0; i < 200; i++) step(1, 0, 0, 1, 0, 2'd0, "R7");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0, 2'd0, "R6");
        // R8: mask filtering of a pending flag
        irq_mask = 3'b110; idle("R8");
        irq_mask = 3'b001; idle("R8");
        // R6: saturated value read back
        read(2'd0, "R6");
        // R10: event coincident with read
        for (int i = 0; i < 3; i++) step(0, 0, 1, 0, 0, 2'd0, "R10");
        step(0, 0, 1, 0, 1, 2'd2, "R10");
        read(2'd2, "R10");
        // R8: two tallies pending, mask selects either
        for (int i = 0; i < 130; i++) step(0, 1, 1, 1, 0, 2'd0, "R7");
        irq_mask = 3'b000; idle("R8");
        irq_mask = 3'b100; idle("R8");
        irq_mask = 3'b010; idle("R8");
        read(2'd1, "R9");
        read(2'd2, "R9");
        idle("R9");
        finish_run();
    end
endmodule